// File: doc/BRIEF.md
# Two-Entry Conversion Result Queue

This block sits between an analog converter and the register read path of a small controller. Each completed conversion presents a raw 11-bit value and a channel tag bit. The block formats these into a 16-bit result word and stores the word in a two-entry first-in first-out queue. The register reader sees the oldest stored word, or the live converter word when the queue is empty. A read strobe removes the oldest entry.

The block also keeps a 2-bit occupancy code, a conversion-complete flag and an overflow flag. Software clears each flag by writing 1. An interrupt line goes high when a set flag has its enable bit high. A flush strobe empties the queue. Bus decoding and the converter are outside the block.

Top module: `adc_result_fifo`

## Requirements
- R1: Words leave the queue in the order they arrived. `rdData` shows the oldest entry. A `rdStrobe` while the queue holds data removes that entry at the clock edge.
- R2: `fifoCount` reads 2'b00 when the queue is empty, 2'b01 with one entry and 2'b10 with two entries. The error code 2'b11 is never produced.
- R3: While the queue is empty, `rdData` shows the word formed from the current `convValue`/`convTag` inputs. A `rdStrobe` at that time leaves the count unchanged.
- R4: Result word layout: bits 10:0 hold the value, bit 11 holds the channel tag, and bits 15:12 are always 0.
- R5: Bit 11 equals `convTag` when `altMode` is 1. It is 0 when `altMode` is 0.
- R6: With `resSel` = 0, bits 9:0 are `convValue[9:0]` and bit 10 is 0. With `resSel` = 1, bits 10:0 are `convValue[10:0]`.
- R7: A `convDone` that arrives while the queue is full and no entry is being read out is dropped. It sets `ovfFlag` and leaves the stored entries unchanged. If a read happens in the same cycle, the new word is accepted and no overflow is raised.
- R8: Every `convDone` sets `doneFlag` at the next edge. `clrDoneW1c` clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R9: `clrOvfW1c` clears `ovfFlag`. If an overflow and a clear fall in the same cycle, the flag stays set.
- R10: `irq` = (`doneFlag` AND `ieDone`) OR (`ovfFlag` AND `ieOvf`).
- R11: `flushReq` empties the queue at the next edge. A result arriving in the same cycle is discarded without an overflow, but it still sets `doneFlag`. A read in that cycle has no further effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convDone | input | 1 | A conversion result is valid this cycle |
| convValue | input | 11 | Raw converter value |
| convTag | input | 1 | Channel identity from the converter |
| altMode | input | 1 | 1 = alternating channel mode |
| resSel | input | 1 | 0 = 10-bit result, 1 = 11-bit result |
| rdStrobe | input | 1 | Result register read |
| flushReq | input | 1 | Empty the queue |
| clrDoneW1c | input | 1 | Write-1 clear of the completion flag |
| clrOvfW1c | input | 1 | Write-1 clear of the overflow flag |
| ieDone | input | 1 | Completion interrupt enable |
| ieOvf | input | 1 | Overflow interrupt enable |
| rdData | output | 16 | Oldest entry, or the live word when empty |
| fifoCount | output | 2 | Occupancy code |
| doneFlag | output | 1 | Conversion-complete flag |
| ovfFlag | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Several events can land in the same cycle: a new result reaching a full queue while it is read, a flag being set while software clears it, and a flush together with an arriving result. A long pseudo-random sweep drives all strobes together at densities that keep the queue near full. Directed sequences then force each of these collisions. After every edge, the bench compares the occupancy code, the visible word, both flags and the interrupt against a queue model computed from the requirements.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  localparam int VAL_W   = 11;
  localparam int ENTRY_W = VAL_W + 1;
  localparam int WORD_W  = 16;
  localparam int DEPTH   = 2;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int PTR_W   = $clog2(DEPTH);

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrobe_t;
endpackage

// File: rtl/adc_fifo_ctrl.sv
module adc_fifo_ctrl
  import adc_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             convDone,
  input  logic             rdStrobe,
  input  logic             flushReq,
  input  logic             clrDoneW1c,
  input  logic             clrOvfW1c,
  input  logic             ieDone,
  input  logic             ieOvf,
  output fifoStrobe_t      strobe,
  output logic [CNT_W-1:0] count,
  output logic             doneFlag,
  output logic             ovfFlag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic isEmpty, isFull, setOvf;

  assign isEmpty = (count == '0);
  assign isFull  = (count == FULL_CNT);

  always_comb begin
    strobe.flush = flushReq;
    strobe.pop   = rdStrobe & ~isEmpty & ~flushReq;
    strobe.push  = convDone & ~flushReq & (~isFull | strobe.pop);
    setOvf       = convDone & ~flushReq & isFull & ~strobe.pop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      doneFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      if (strobe.flush)
        count <= '0;
      else if (strobe.push && !strobe.pop)
        count <= count + 1'b1;
      else if (strobe.pop && !strobe.push)
        count <= count - 1'b1;

      if (convDone)        doneFlag <= 1'b1;
      else if (clrDoneW1c) doneFlag <= 1'b0;

      if (setOvf)          ovfFlag <= 1'b1;
      else if (clrOvfW1c)  ovfFlag <= 1'b0;
    end
  end

  assign irq = (doneFlag & ieDone) | (ovfFlag & ieOvf);

  p_count_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  p_ovf_on_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && isFull && !rdStrobe && !flushReq) |=> (ovfFlag && count == FULL_CNT));
  p_read_full_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && isFull && rdStrobe && !flushReq) |=> (count == FULL_CNT));
  p_done_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> doneFlag);
  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (count == '0));
endmodule

// File: rtl/adc_fifo_datapath.sv
module adc_fifo_datapath
  import adc_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [CNT_W-1:0]  count,
  input  logic [VAL_W-1:0]  convValue,
  input  logic              convTag,
  input  logic              altMode,
  input  logic              resSel,
  output logic [WORD_W-1:0] rdData
);
  logic [ENTRY_W-1:0] entryQ [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [VAL_W-1:0]   valField;
  logic [ENTRY_W-1:0] liveEntry, headEntry;

  always_comb begin
    valField  = resSel ? convValue : {1'b0, convValue[VAL_W-2:0]};
    liveEntry = {convTag & altMode, valField};
    headEntry = entryQ[rdPtr];
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)
        entryQ[e] <= '0;
      else if (strobe.push && !strobe.flush && wrPtr == PTR_W'(e))
        entryQ[e] <= liveEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  assign rdData = {{(WORD_W-ENTRY_W){1'b0}}, (count == '0) ? liveEntry : headEntry};

  p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (count != CNT_W'(DEPTH) || strobe.pop));
  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH) && !strobe.pop && !strobe.flush) |=> $stable(headEntry));
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdData[WORD_W-1:ENTRY_W] == '0);
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo
  import adc_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic [VAL_W-1:0]  convValue,
  input  logic              convTag,
  input  logic              altMode,
  input  logic              resSel,
  input  logic              rdStrobe,
  input  logic              flushReq,
  input  logic              clrDoneW1c,
  input  logic              clrOvfW1c,
  input  logic              ieDone,
  input  logic              ieOvf,
  output logic [WORD_W-1:0] rdData,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              doneFlag,
  output logic              ovfFlag,
  output logic              irq
);
  fifoStrobe_t strobe;

  adc_fifo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .convDone(convDone), .rdStrobe(rdStrobe),
    .flushReq(flushReq), .clrDoneW1c(clrDoneW1c), .clrOvfW1c(clrOvfW1c),
    .ieDone(ieDone), .ieOvf(ieOvf), .strobe(strobe), .count(fifoCount),
    .doneFlag(doneFlag), .ovfFlag(ovfFlag), .irq(irq)
  );

  adc_fifo_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(fifoCount),
    .convValue(convValue), .convTag(convTag), .altMode(altMode),
    .resSel(resSel), .rdData(rdData)
  );
endmodule

// File: tb/adc_result_fifo_bench.sv
module adc_result_fifo_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convDone = 0, convTag = 0, altMode = 0, resSel = 0, rdStrobe = 0, flushReq = 0;
  logic clrDoneW1c = 0, clrOvfW1c = 0, ieDone = 0, ieOvf = 0;
  logic [10:0] convValue = '0;
  logic [15:0] rdData;
  logic [1:0]  fifoCount;
  logic doneFlag, ovfFlag, irq;

  int checks = 0, failures = 0;
  logic [15:0] mq [2];
  int mcnt = 0;
  logic mDone = 0, mOvf = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #5 clk = ~clk;

  adc_result_fifo u_adc_result_fifo (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convValue(convValue),
    .convTag(convTag), .altMode(altMode), .resSel(resSel), .rdStrobe(rdStrobe),
    .flushReq(flushReq), .clrDoneW1c(clrDoneW1c), .clrOvfW1c(clrOvfW1c),
    .ieDone(ieDone), .ieOvf(ieOvf), .rdData(rdData), .fifoCount(fifoCount),
    .doneFlag(doneFlag), .ovfFlag(ovfFlag), .irq(irq)
  );

  function automatic logic [15:0] fmt(logic [10:0] v, logic t, logic alt, logic res);
    logic [10:0] vv;
    vv = res ? v : {1'b0, v[9:0]};
    return {4'b0000, t & alt, vv};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    logic [15:0] expWord;
    expWord = (mcnt == 0) ? fmt(convValue, convTag, altMode, resSel) : mq[0];
    chk(fifoCount == 2'(mcnt), {"R2 count ", tag}, 32'(fifoCount), 32'(mcnt));
    chk(rdData == expWord, {"R1/R3/R4/R5/R6 word ", tag}, 32'(rdData), 32'(expWord));
    chk(doneFlag == mDone, {"R8 done ", tag}, 32'(doneFlag), 32'(mDone));
    chk(ovfFlag == mOvf, {"R9 ovf ", tag}, 32'(ovfFlag), 32'(mOvf));
    chk(irq == ((mDone & ieDone) | (mOvf & ieOvf)), {"R10 irq ", tag},
        32'(irq), 32'((mDone & ieDone) | (mOvf & ieOvf)));
  endtask

  // Drive at negedge, update model, compare one time unit after the edge.
  task automatic step(string tag);
    logic [15:0] w;
    bit pop, push, setOvf;
    w = fmt(convValue, convTag, altMode, resSel);
    pop    = rdStrobe && mcnt > 0 && !flushReq;
    push   = convDone && !flushReq && (mcnt < 2 || pop);
    setOvf = convDone && !flushReq && mcnt == 2 && !pop;
    @(posedge clk);
    if (flushReq) mcnt = 0;
    else begin
      if (pop) begin mq[0] = mq[1]; mcnt--; end
      if (push) begin mq[mcnt] = w; mcnt++; end
    end
    if (convDone) mDone = 1; else if (clrDoneW1c) mDone = 0;
    if (setOvf) mOvf = 1; else if (clrOvfW1c) mOvf = 0;
    #1;
    compareAll(tag);
    @(negedge clk);
  endtask

  task automatic idle();
    convDone = 0; rdStrobe = 0; flushReq = 0; clrDoneW1c = 0; clrOvfW1c = 0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // Reset state: empty, flags low (R2, R8, R9, R10)
    compareAll("reset");

    // R6 10-bit mode: bit 10 is masked off
    resSel = 0; altMode = 1; convTag = 1; convValue = 11'h7FF; ieDone = 1;
    convDone = 1; step("R6 res10 push"); idle();
    chk(rdData == 16'h0BFF, "R6 R5 10-bit word", 32'(rdData), 32'h0BFF);
    chk(irq == 1'b1, "R10 done irq", 32'(irq), 1);
    // R5: the tag is dropped in manual mode
    resSel = 1; altMode = 0; convValue = 11'h555; convDone = 1; step("R5 manual"); idle();
    // Full: drop the third result, set ovf, contents unchanged (R7)
    convValue = 11'h123; convDone = 1; step("R7 overflow"); idle();
    chk(ovfFlag == 1 && rdData == 16'h0BFF, "R7 drop keeps head", 32'(rdData), 32'h0BFF);
    // Set wins over w1c (R8, R9)
    convDone = 1; clrDoneW1c = 1; clrOvfW1c = 1; step("R8 R9 set wins"); idle();
    chk(ovfFlag == 1 && doneFlag == 1, "R9 set beats clear", 32'({doneFlag, ovfFlag}), 32'h3);
    clrOvfW1c = 1; clrDoneW1c = 1; step("R9 clear"); idle();
    // Full with simultaneous read: the new word is accepted (R7)
    convValue = 11'h0AA; convDone = 1; rdStrobe = 1; step("R7 read+push full"); idle();
    chk(ovfFlag == 0 && rdData == 16'h0555, "R7 no ovf on read", 32'(rdData), 32'h0555);
    rdStrobe = 1; step("R1 pop"); idle();
    chk(rdData == 16'h00AA, "R1 order", 32'(rdData), 32'h00AA);
    // Flush together with an arriving result (R11)
    convDone = 1; flushReq = 1; rdStrobe = 1; step("R11 flush"); idle();
    chk(fifoCount == 0 && ovfFlag == 0, "R11 flush empties", 32'(fifoCount), 0);
    // Empty read returns the live word and leaves the count at zero (R3)
    convValue = 11'h3C3; altMode = 1; convTag = 1; rdStrobe = 1; step("R3 live"); idle();
    chk(rdData == 16'h0BC3 && fifoCount == 0, "R3 live word", 32'(rdData), 32'h0BC3);

    // Sweep: pseudo-random strobes with a dense push rate
    for (int i = 0; i < 3000; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      convDone   = lfsr[0] | lfsr[1];
      rdStrobe   = lfsr[2] & lfsr[3];
      flushReq   = (lfsr[7:4] == 4'h0);
      clrDoneW1c = lfsr[8] & lfsr[9];
      clrOvfW1c  = lfsr[10] & lfsr[11];
      convValue  = lfsr[22:12];
      convTag    = lfsr[23];
      altMode    = lfsr[24];
      resSel     = lfsr[25];
      ieDone     = lfsr[26];
      ieOvf      = lfsr[27];
      step("R1 R7 sweep");
    end
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule